// File: doc/BRIEF.md
# Microcode Sequencer

This block steps through a fixed microprogram held in an internal read-only store. The store is indexed by the microaddress register. In a fetch cycle the addressed word is copied into a word register. In the following execute cycle the control field of that word drives the control outputs, and the word's own link field gives the next microaddress. Every microinstruction therefore takes exactly two clock cycles. Control outputs are zero outside execute cycles.

The sequencer waits at address 0 after reset until `start` is seen. It then runs by itself until it reaches a word whose link field points back to its own address. That word is treated as the end of the program: a halt flag rises and the sequencer stays put until the next reset. The store contents are computed inside the design from two parameters, a stride and a halt address, so no external file is involved.

Top module: `ucode_sequencer`

## Requirements
- R1: While `rst_n` is low, and afterwards until `start` is sampled high, `uaddr` is 0, `ctrl_word` is 0 and `halted` is 0.
- R2: When `start` is high at a rising edge while the sequencer waits, the next cycle is a fetch cycle (`ctrl_word` 0). The cycle after that is the execute cycle for address 0.
- R3: `ctrl_word` is 0 in every cycle that is not an execute cycle: waiting, fetch and halted.
- R4: Each store word is CTRL_W+ADDR_W bits wide, with the control field in the upper CTRL_W bits and the link field in the lower ADDR_W bits. In the execute cycle for address a, `ctrl_word` equals the control field of word a. With default widths that field is {a, ~a, a}: bit i is a[i mod 6], inverted when (i div 6) is odd.
- R5: The link field of word a is (a + STRIDE) mod 2^ADDR_W, except that word HALT_ADDR links to itself. At the edge that ends an execute cycle, `uaddr` takes the link value. A fetch cycle follows, so every step lasts two cycles and `uaddr` is constant within it.
- R6: At the edge that ends the execute cycle of a self-linked word, `halted` rises. From then until reset, `uaddr` keeps that address, `ctrl_word` is 0 and `halted` stays 1.
- R7: `start` has no effect during fetch, execute or halted cycles. The address sequence and the outputs are the same whether it is high or low.
- R8: Driving `rst_n` low at any point, including mid-program or while halted, returns the outputs to the R1 state. A later `start` reruns the program from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins the microprogram when the sequencer is waiting |
| ctrl_word | output | CTRL_W | Control field of the executing word; 0 outside execute cycles |
| uaddr | output | ADDR_W | Current microaddress register |
| halted | output | 1 | High once a self-linked word has executed |

## Verification
The bench uses the defaults: ADDR_W 6 (a 64-word store), CTRL_W 18, STRIDE 5 and HALT_ADDR 42. An odd stride makes the walk from address 0 visit addresses in a full cycle modulo 64, so the run reaches the halt word after 34 steps and wraps past address 63 on the way. Each program run takes about 70 cycles, so random start pulses and occasional resets produce many full runs to halt, runs cut short by reset, and start pulses that land in every phase.

// File: rtl/ucseq_pkg.sv
package ucseq_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FETCH = 2'd1,
    PH_EXEC  = 2'd2,
    PH_HALT  = 2'd3
  } phase_t;
endpackage

// File: rtl/ucseq_store.sv
module ucseq_store #(
  parameter int ADDR_W    = 6,
  parameter int CTRL_W    = 18,
  parameter int STRIDE    = 5,
  parameter int HALT_ADDR = 42,
  localparam int DEPTH    = 1 << ADDR_W,
  localparam int WORD_W   = CTRL_W + ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [WORD_W-1:0] rdata
);
  // control field: address bits repeated, every other group inverted
  function automatic logic [CTRL_W-1:0] ctrl_of(input logic [ADDR_W-1:0] a);
    logic [CTRL_W-1:0] w;
    for (int i = 0; i < CTRL_W; i++) begin
      w[i] = a[i % ADDR_W] ^ (((i / ADDR_W) % 2) == 1);
    end
    return w;
  endfunction

  // link field: fixed stride, self-loop at the halt word
  function automatic logic [ADDR_W-1:0] link_of(input logic [ADDR_W-1:0] a);
    if (a == ADDR_W'(HALT_ADDR)) return a;
    return a + ADDR_W'(STRIDE);
  endfunction

  logic [WORD_W-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign rom[g] = {ctrl_of(ADDR_W'(g)), link_of(ADDR_W'(g))};
  end

  assign rdata = rom[addr];
endmodule

// File: rtl/ucseq_phase.sv
module ucseq_phase
  import ucseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   self_loop,
  output phase_t phase
);
  phase_t phase_d;

  always_comb begin
    phase_d = phase;
    unique case (phase)
      PH_IDLE:  if (start) phase_d = PH_FETCH;
      PH_FETCH: phase_d = PH_EXEC;
      PH_EXEC:  phase_d = self_loop ? PH_HALT : PH_FETCH;
      PH_HALT:  phase_d = PH_HALT;
      default:  phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_d;
  end
endmodule

// File: rtl/ucseq_regs.sv
module ucseq_regs #(
  parameter int ADDR_W  = 6,
  parameter int CTRL_W  = 18,
  localparam int WORD_W = CTRL_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_word,
  input  logic              advance,
  input  logic [WORD_W-1:0] store_word,
  output logic [ADDR_W-1:0] car,
  output logic [WORD_W-1:0] cdr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      car <= '0;
      cdr <= '0;
    end else begin
      if (load_word) cdr <= store_word;
      if (advance)   car <= cdr[ADDR_W-1:0];
    end
  end
endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
  import ucseq_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int CTRL_W    = 18,
  parameter int STRIDE    = 5,
  parameter int HALT_ADDR = 42
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [CTRL_W-1:0] ctrl_word,
  output logic [ADDR_W-1:0] uaddr,
  output logic              halted
);
  localparam int WORD_W = CTRL_W + ADDR_W;

  phase_t            phase;
  logic [ADDR_W-1:0] car;
  logic [WORD_W-1:0] cdr;
  logic [WORD_W-1:0] store_word;

  // named internal events
  logic              fetch_phase;
  logic              exec_phase;
  logic              self_loop;
  logic              advance;
  logic [ADDR_W-1:0] link_field;

  assign fetch_phase = (phase == PH_FETCH);
  assign exec_phase  = (phase == PH_EXEC);
  assign link_field  = cdr[ADDR_W-1:0];
  assign self_loop   = exec_phase && (link_field == car);
  assign advance     = exec_phase && !self_loop;

  ucseq_store #(
    .ADDR_W(ADDR_W), .CTRL_W(CTRL_W), .STRIDE(STRIDE), .HALT_ADDR(HALT_ADDR)
  ) u_store (
    .addr (car),
    .rdata(store_word)
  );

  ucseq_phase u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .self_loop(self_loop),
    .phase    (phase)
  );

  ucseq_regs #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_word (fetch_phase),
    .advance   (advance),
    .store_word(store_word),
    .car       (car),
    .cdr       (cdr)
  );

  assign ctrl_word = exec_phase ? cdr[WORD_W-1:ADDR_W] : '0;
  assign uaddr     = car;
  assign halted    = (phase == PH_HALT);

  // R1: waiting sequencer sits at address 0
  assert_idle_home_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> (car == '0));

  // R2 / R5: fetch is always followed by execute with the address held
  assert_fetch_then_exec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_phase |=> (exec_phase && $stable(car)));

  // R4: word register holds the store word of the current address during execute
  assert_word_matches_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    exec_phase |-> (cdr == store_word));

  // R5: address register follows the link field after execute
  assert_link_followed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (car == $past(link_field) && fetch_phase));

  // R6: halt is sticky, address frozen, outputs quiet
  assert_halt_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(uaddr) && ctrl_word == '0));

  // R7: once running, start never sends the sequencer back to waiting
  assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_phase || exec_phase || halted) |=> (phase != PH_IDLE));
endmodule

// File: tb/tb_ucode_sequencer.sv
module tb_ucode_sequencer;
  localparam int AW = 6;
  localparam int CW = 18;
  localparam int STEP = 5;
  localparam int STOP_AT = 42;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [CW-1:0] ctrl_word;
  logic [AW-1:0] uaddr;
  logic          halted;

  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;

  // model: 0 waiting, 1 fetch, 2 execute, 3 halted
  int m_ph = 0;
  logic [AW-1:0] m_addr = '0;

  always #5 clk = ~clk;

  ucode_sequencer dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .ctrl_word(ctrl_word), .uaddr(uaddr), .halted(halted)
  );

  function automatic logic [CW-1:0] exp_ctrl(input logic [AW-1:0] a);
    return {a, ~a, a};
  endfunction

  function automatic logic [AW-1:0] exp_link(input logic [AW-1:0] a);
    logic [AW-1:0] s;
    s = AW'((int'(a) + STEP) % 64);
    if (int'(a) == STOP_AT) return a;
    return s;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    if (!rst_n) begin
      m_ph = 0; m_addr = '0;
    end else begin
      case (m_ph)
        0: if (start) m_ph = 1;
        1: m_ph = 2;
        2: if (exp_link(m_addr) == m_addr) m_ph = 3;
           else begin m_addr = exp_link(m_addr); m_ph = 1; end
        default: m_ph = 3;
      endcase
    end
  endtask

  task automatic check_cycle();
    chk(m_ph == 0 ? "R1 uaddr" : "R5 uaddr", 32'(uaddr), 32'(m_addr));
    chk(m_ph == 2 ? "R4 ctrl_word" : "R3 ctrl_word", 32'(ctrl_word),
        m_ph == 2 ? 32'(exp_ctrl(m_addr)) : 32'd0);
    chk("R6 halted", 32'(halted), 32'(m_ph == 3));
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_cycle();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    // R1: reset state
    tick(); tick();
    chk("R1 reset uaddr", 32'(uaddr), 32'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) tick();
    chk("R1 idle halted", 32'(halted), 32'd0);

    // R2: start latency, directed
    start = 1'b1; tick(); start = 1'b0;
    chk("R2 fetch cycle ctrl", 32'(ctrl_word), 32'd0);
    tick();
    chk("R2 first exec ctrl", 32'(ctrl_word), 32'(exp_ctrl('0)));

    // R7: start held high through the whole run, then at halt
    start = 1'b1;
    for (int i = 0; i < 80; i++) tick();
    chk("R7 run completed with start high", 32'(halted), 32'd1);
    chk("R6 halt address", 32'(uaddr), 32'(STOP_AT));
    start = 1'b0;
    for (int i = 0; i < 4; i++) tick();
    chk("R7 start ignored while halted", 32'(uaddr), 32'(STOP_AT));

    // R8: reset while halted, rerun
    rst_n = 1'b0; tick();
    chk("R8 reset from halt uaddr", 32'(uaddr), 32'd0);
    chk("R8 reset from halt flag", 32'(halted), 32'd0);
    rst_n = 1'b1; start = 1'b1; tick(); start = 1'b0;
    for (int i = 0; i < 20; i++) tick();
    // R8: reset mid-program
    rst_n = 1'b0; tick();
    chk("R8 mid-run reset uaddr", 32'(uaddr), 32'd0);
    rst_n = 1'b1;

    // random phase: start pulses and sparse resets
    for (int i = 0; i < 6000; i++) begin
      start = (($urandom % 4) == 0);
      rst_n = (($urandom % 300) != 0);
      tick();
    end
    rst_n = 1'b1; start = 1'b0; tick();

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule